// File: doc/BRIEF.md
# Serial GPIO Bitstream Engine

This block runs a chained shift-register serial GPIO bus. Logically the bus is a grid of ports, and each port carries one to several bit positions. On every burst the engine sends the output value of each active bit and samples the returned input value. Both use one divided serial clock. After the last bit it raises a load strobe for one serial period. That strobe latches the external output chain, and at its end the sampled inputs move into the input registers in one step.

Software sets up the block through a small write/read register port. The settings are:
- which ports take part;
- how many bits each port carries;
- the divisor for the serial clock;
- a 3-bit source field per port and bit index;
- two burst controls.

The first control is a repeat mode, which restarts bursts after a gap of a power-of-two number of serial periods. The second is a one-shot bit, which starts a single burst and is cleared by hardware when that burst ends.

Top module: `sgpio_engine`

Register map (word address on `wr_addr`/`rd_addr`):
- 0, control: [1:0] bits per port minus one, [2] repeat mode, [3] one-shot, [7:4] gap exponent g.
- 1, divisor: [11:0] divisor.
- 2, port mask: bit p enables port p.
- 4+n, read-only input register for bit index n.
- 32+p, output word of port p. It holds a 3-bit field per bit index n at [3n+2:3n].

## Requirements
- R1: A burst shifts (width field + 1) bits for each enabled port. Disabled ports are skipped and cost no serial clock periods.
- R2: The shift order runs from the highest enabled port down to the lowest. Within a port the bits go in rising bit index, starting at bit 0.
- R3: While a bit of port p, index n, is being shifted, `sdo_o` equals bit 3n of the output word of port p. Bits 3n+1 and 3n+2 have no effect.
- R4: In input register n, bit p holds `sdi_i` as sampled during the serial period of port p, bit n. Bits of disabled ports, and indices above the width field, read 0 after a burst.
- R5: The serial period P is the divisor field, or 2 if the field is below 2. `sclk_o` is low for floor(P/2) system cycles and then high for the remainder of the period. `sdi_i` is sampled at the end of the period, and `sdo_o` does not change while `sclk_o` is high.
- R6: After the last bit, `sload_o` is high for exactly P system cycles with `sclk_o` low. The input registers change only at the end of that strobe.
- R7: With repeat mode clear, writing the one-shot bit as 1 starts one burst at once. The bit reads 1 until the load strobe ends and reads 0 after that.
- R8: While repeat mode is set, the one-shot bit is never cleared by hardware.
- R9: With repeat mode set, bursts repeat. Consecutive load-strobe rises lie P*(bits + 1 + 2^g) + 1 system cycles apart. Once repeat mode is cleared, no further burst starts after the current one.
- R10: After reset all serial outputs are low, every register reads 0 and no burst runs.
- R11: A burst with no enabled port consists only of the load period and leaves all input registers at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| sclk_o | output | 1 | Serial clock to the shift-register chain |
| sdo_o | output | 1 | Serial output data |
| sload_o | output | 1 | Load strobe that latches the chain |
| sdi_i | input | 1 | Serial input data returned by the chain |

## Verification
The bench builds the engine with 8 ports and 4 bits per port and keeps the 12-bit divisor and 4-bit gap field. A full burst then lasts at most 32 bits, so each table vector finishes in a few hundred cycles. This lets the bench cover every width value and several masks: all ports, only the end ports, a sparse mask, a single port and an empty mask. The divisor values 0 and 1 are included and must clamp to 2. The bench also models the external chain at each rising serial clock, so the shift order, the output field decode and the input grid mapping are all checked bit by bit. Repeat-mode spacing is measured with a gap exponent of 1.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_GAP   = 2'd3
  } sg_state_e;

  localparam int ADDR_W      = 6;
  localparam int A_CTRL      = 0;
  localparam int A_DIV       = 1;
  localparam int A_MASK      = 2;
  localparam int A_IN_BASE   = 4;
  localparam int A_WORD_BASE = 32;

  localparam int CTL_WID_LSB = 0;
  localparam int CTL_AUTO    = 2;
  localparam int CTL_SHOT    = 3;
  localparam int CTL_GAP_LSB = 4;

  localparam int FIELD_W     = 3;

endpackage

// File: rtl/sgpio_clkdiv.sv
module sgpio_clkdiv #(
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [DIVW-1:0] div_i,
  output logic            hi_o,
  output logic            last_o,
  output logic [DIVW-1:0] period_o
);

  logic [DIVW-1:0] cnt_q, cnt_d;
  logic [DIVW-1:0] per_q, per_d;

  // Period is frozen while a burst runs; re-sampled while idle.
  always_comb begin
    per_d = per_q;
    if (!run_i) begin
      per_d = (div_i < DIVW'(2)) ? DIVW'(2) : div_i;
    end
  end

  assign last_o = run_i && (cnt_q == per_q - DIVW'(1));
  assign hi_o   = run_i && (cnt_q >= (per_q >> 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || last_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= DIVW'(2);
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign period_o = per_q;

endmodule

// File: rtl/sgpio_regs.sv
module sgpio_regs
  import sgpio_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIVW    = 12,
  parameter int GAPW    = 4,
  localparam int BW     = $clog2(MAXBITS),
  localparam int FW     = FIELD_W * MAXBITS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [31:0]                     wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [31:0]                     rd_data,
  input  logic                            shot_clr_i,
  input  logic                            commit_i,
  input  logic [MAXBITS-1:0][NPORTS-1:0]  shadow_i,
  output logic [BW-1:0]                   wid_o,
  output logic                            auto_o,
  output logic                            shot_o,
  output logic [GAPW-1:0]                 gap_o,
  output logic [DIVW-1:0]                 div_o,
  output logic [NPORTS-1:0]               mask_o,
  output logic [NPORTS-1:0][FW-1:0]       words_o,
  output logic [MAXBITS-1:0][NPORTS-1:0]  in_o
);

  logic [BW-1:0]                  wid_q, wid_d;
  logic                           auto_q, auto_d;
  logic                           shot_q, shot_d;
  logic [GAPW-1:0]                gap_q, gap_d;
  logic [DIVW-1:0]                div_q, div_d;
  logic [NPORTS-1:0]              mask_q, mask_d;
  logic [MAXBITS-1:0][NPORTS-1:0] in_q, in_d;

  logic wr_ctrl, wr_div, wr_mask;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_div  = wr_en && (wr_addr == ADDR_W'(A_DIV));
  assign wr_mask = wr_en && (wr_addr == ADDR_W'(A_MASK));

  always_comb begin
    wid_d  = wid_q;
    auto_d = auto_q;
    shot_d = shot_q;
    gap_d  = gap_q;
    div_d  = div_q;
    mask_d = mask_q;
    in_d   = in_q;
    if (shot_clr_i) begin
      shot_d = 1'b0;
    end
    if (wr_ctrl) begin
      wid_d  = wr_data[CTL_WID_LSB +: BW];
      auto_d = wr_data[CTL_AUTO];
      shot_d = wr_data[CTL_SHOT];
      gap_d  = wr_data[CTL_GAP_LSB +: GAPW];
    end
    if (wr_div) begin
      div_d = wr_data[DIVW-1:0];
    end
    if (wr_mask) begin
      mask_d = wr_data[NPORTS-1:0];
    end
    if (commit_i) begin
      in_d = shadow_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q  <= '0;
      auto_q <= 1'b0;
      shot_q <= 1'b0;
      gap_q  <= '0;
      div_q  <= '0;
      mask_q <= '0;
      in_q   <= '0;
    end else begin
      wid_q  <= wid_d;
      auto_q <= auto_d;
      shot_q <= shot_d;
      gap_q  <= gap_d;
      div_q  <= div_d;
      mask_q <= mask_d;
      in_q   <= in_d;
    end
  end

  // One output word per port, each with its own write enable.
  for (genvar p = 0; p < NPORTS; p++) begin : g_word
    logic          we;
    logic [FW-1:0] word_q, word_d;
    assign we = wr_en && (wr_addr == ADDR_W'(A_WORD_BASE + p));
    always_comb begin
      word_d = word_q;
      if (we) begin
        word_d = wr_data[FW-1:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else begin
        word_q <= word_d;
      end
    end
    assign words_o[p] = word_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CTRL)) begin
      rd_data[CTL_WID_LSB +: BW]  = wid_q;
      rd_data[CTL_AUTO]           = auto_q;
      rd_data[CTL_SHOT]           = shot_q;
      rd_data[CTL_GAP_LSB +: GAPW] = gap_q;
    end else if (rd_addr == ADDR_W'(A_DIV)) begin
      rd_data[DIVW-1:0] = div_q;
    end else if (rd_addr == ADDR_W'(A_MASK)) begin
      rd_data[NPORTS-1:0] = mask_q;
    end else begin
      for (int n = 0; n < MAXBITS; n++) begin
        if (rd_addr == ADDR_W'(A_IN_BASE + n)) begin
          rd_data[NPORTS-1:0] = in_q[n];
        end
      end
      for (int p = 0; p < NPORTS; p++) begin
        if (rd_addr == ADDR_W'(A_WORD_BASE + p)) begin
          rd_data[FW-1:0] = words_o[p];
        end
      end
    end
  end

  assign wid_o  = wid_q;
  assign auto_o = auto_q;
  assign shot_o = shot_q;
  assign gap_o  = gap_q;
  assign div_o  = div_q;
  assign mask_o = mask_q;
  assign in_o   = in_q;

endmodule

// File: rtl/sgpio_burst.sv
module sgpio_burst
  import sgpio_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int GAPW    = 4,
  localparam int BW     = $clog2(MAXBITS),
  localparam int PW     = $clog2(NPORTS),
  localparam int FW     = FIELD_W * MAXBITS,
  localparam int GCW    = 1 << GAPW
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [BW-1:0]                   wid_i,
  input  logic                            auto_i,
  input  logic                            shot_i,
  input  logic [GAPW-1:0]                 gap_i,
  input  logic [NPORTS-1:0]               mask_i,
  input  logic [NPORTS-1:0][FW-1:0]       words_i,
  input  logic                            hi_i,
  input  logic                            last_i,
  input  logic                            sdi_i,
  output logic                            run_o,
  output logic                            sclk_o,
  output logic                            sdo_o,
  output logic                            sload_o,
  output logic                            commit_o,
  output logic                            shot_clr_o,
  output logic [MAXBITS-1:0][NPORTS-1:0]  shadow_o
);

  sg_state_e                      st_q, st_d;
  logic [PW-1:0]                  port_q, port_d;
  logic [BW-1:0]                  bit_q, bit_d;
  logic [BW-1:0]                  wid_q, wid_d;
  logic [NPORTS-1:0]              msk_q, msk_d;
  logic [GCW-1:0]                 gcnt_q, gcnt_d;
  logic [MAXBITS-1:0][NPORTS-1:0] shd_q, shd_d;

  // Highest set bit of m below lim; MSB of the result flags a hit.
  function automatic logic [PW:0] pick_below(input logic [NPORTS-1:0] m,
                                             input logic [PW:0] lim);
    logic [PW:0] r;
    r = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (m[i] && ((PW+1)'(i) < lim)) begin
        r = {1'b1, PW'(i)};
      end
    end
    return r;
  endfunction

  logic [PW:0]    first_hit, next_hit;
  logic [GCW-1:0] gap_lim;
  logic [FW-1:0]  cur_word;

  assign first_hit = pick_below(mask_i, (PW+1)'(NPORTS));
  assign next_hit  = pick_below(msk_q, {1'b0, port_q});
  assign gap_lim   = (GCW'(1) << gap_i) - GCW'(1);
  assign cur_word  = words_i[port_q];

  always_comb begin
    st_d       = st_q;
    port_d     = port_q;
    bit_d      = bit_q;
    wid_d      = wid_q;
    msk_d      = msk_q;
    gcnt_d     = gcnt_q;
    shd_d      = shd_q;
    commit_o   = 1'b0;
    shot_clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (auto_i || shot_i) begin
          msk_d = mask_i;
          wid_d = wid_i;
          shd_d = '0;
          bit_d = '0;
          if (first_hit[PW]) begin
            st_d   = ST_SHIFT;
            port_d = first_hit[PW-1:0];
          end else begin
            st_d = ST_LOAD;
          end
        end
      end
      ST_SHIFT: begin
        if (last_i) begin
          shd_d[bit_q][port_q] = sdi_i;
          if (bit_q == wid_q) begin
            bit_d = '0;
            if (next_hit[PW]) begin
              port_d = next_hit[PW-1:0];
            end else begin
              st_d = ST_LOAD;
            end
          end else begin
            bit_d = bit_q + BW'(1);
          end
        end
      end
      ST_LOAD: begin
        if (last_i) begin
          commit_o = 1'b1;
          if (auto_i) begin
            st_d   = ST_GAP;
            gcnt_d = '0;
          end else begin
            st_d       = ST_IDLE;
            shot_clr_o = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (last_i) begin
          if (gcnt_q == gap_lim) begin
            st_d = ST_IDLE;
          end else begin
            gcnt_d = gcnt_q + GCW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      port_q <= '0;
      bit_q  <= '0;
      wid_q  <= '0;
      msk_q  <= '0;
      gcnt_q <= '0;
      shd_q  <= '0;
    end else begin
      st_q   <= st_d;
      port_q <= port_d;
      bit_q  <= bit_d;
      wid_q  <= wid_d;
      msk_q  <= msk_d;
      gcnt_q <= gcnt_d;
      shd_q  <= shd_d;
    end
  end

  assign run_o    = (st_q != ST_IDLE);
  assign sclk_o   = (st_q == ST_SHIFT) && hi_i;
  assign sload_o  = (st_q == ST_LOAD);
  assign sdo_o    = (st_q == ST_SHIFT) && cur_word[FIELD_W * bit_q];
  assign shadow_o = shd_q;

endmodule

// File: rtl/sgpio_engine.sv
module sgpio_engine
  import sgpio_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIVW    = 12,
  parameter int GAPW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sload_o,
  input  logic              sdi_i
);

  localparam int BW = $clog2(MAXBITS);
  localparam int FW = FIELD_W * MAXBITS;

  logic [BW-1:0]                  cfg_wid;
  logic                           cfg_auto;
  logic                           cfg_shot;
  logic [GAPW-1:0]                cfg_gap;
  logic [DIVW-1:0]                cfg_div;
  logic [NPORTS-1:0]              cfg_mask;
  logic [NPORTS-1:0][FW-1:0]      port_words;
  logic [MAXBITS-1:0][NPORTS-1:0] in_regs;
  logic [MAXBITS-1:0][NPORTS-1:0] shadow;
  logic                           commit;
  logic                           shot_clr;
  logic                           run;
  logic                           ph_hi;
  logic                           ph_last;
  logic [DIVW-1:0]                period;

  sgpio_regs #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .DIVW(DIVW), .GAPW(GAPW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .shot_clr_i(shot_clr), .commit_i(commit), .shadow_i(shadow),
    .wid_o(cfg_wid), .auto_o(cfg_auto), .shot_o(cfg_shot), .gap_o(cfg_gap),
    .div_o(cfg_div), .mask_o(cfg_mask), .words_o(port_words), .in_o(in_regs)
  );

  sgpio_clkdiv #(
    .DIVW(DIVW)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(cfg_div),
    .hi_o(ph_hi), .last_o(ph_last), .period_o(period)
  );

  sgpio_burst #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .GAPW(GAPW)
  ) u_burst (
    .clk(clk), .rst_n(rst_n),
    .wid_i(cfg_wid), .auto_i(cfg_auto), .shot_i(cfg_shot), .gap_i(cfg_gap),
    .mask_i(cfg_mask), .words_i(port_words),
    .hi_i(ph_hi), .last_i(ph_last), .sdi_i(sdi_i),
    .run_o(run), .sclk_o(sclk_o), .sdo_o(sdo_o), .sload_o(sload_o),
    .commit_o(commit), .shot_clr_o(shot_clr), .shadow_o(shadow)
  );

endmodule

// File: rtl/sgpio_engine_chk.sv
module sgpio_engine_chk #(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIVW    = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic                            sclk_o,
  input logic                            sdo_o,
  input logic                            sload_o,
  input logic                            cfg_auto,
  input logic                            cfg_shot,
  input logic [DIVW-1:0]                 period,
  input logic [MAXBITS-1:0][NPORTS-1:0]  in_regs
);

  logic [DIVW:0] ld_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt_q <= '0;
    end else if (sload_o) begin
      ld_cnt_q <= ld_cnt_q + (DIVW+1)'(1);
    end else begin
      ld_cnt_q <= '0;
    end
  end

  // R8
  shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto && cfg_shot && !wr_en) |=> cfg_shot);

  // R5
  sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o) && !$past(wr_en)) |-> $stable(sdo_o));

  // R6
  load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sload_o) |-> (ld_cnt_q == {1'b0, period}));

  // R6
  in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sload_o) |-> $stable(in_regs));

endmodule

bind sgpio_engine sgpio_engine_chk #(
  .NPORTS(NPORTS), .MAXBITS(MAXBITS), .DIVW(DIVW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .sclk_o(sclk_o), .sdo_o(sdo_o), .sload_o(sload_o),
  .cfg_auto(cfg_auto), .cfg_shot(cfg_shot),
  .period(period), .in_regs(in_regs)
);

// File: tb/sgpio_engine_bench.sv
module sgpio_engine_bench;

  localparam int NP = 8;
  localparam int MB = 4;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;
  logic [5:0]  rd_addr;
  logic [31:0] rd_data;
  logic        sclk_o, sdo_o, sload_o, sdi_i;

  sgpio_engine #(.NPORTS(NP), .MAXBITS(MB), .DIVW(12), .GAPW(4)) u_sgpio_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .sload_o(sload_o), .sdi_i(sdi_i)
  );

  // vector: [31:24] mask, [23:22] width-1, [21:10] divisor, [9:0] seed
  localparam logic [31:0] VEC [6] = '{
    {8'hFF, 2'd3, 12'd2, 10'd1},
    {8'h81, 2'd0, 12'd3, 10'd2},
    {8'h5A, 2'd1, 12'd4, 10'd3},
    {8'h01, 2'd2, 12'd1, 10'd4},
    {8'h80, 2'd3, 12'd0, 10'd5},
    {8'h3C, 2'd2, 12'd5, 10'd6}
  };

  int nchk, nfail, cyc;
  int nrise, nexp, cur_seed;
  int op [64];
  int ob [64];
  logic obs [64];
  int hi_run, last_hi, ld_run, last_ld, ld_t0, ld_t1, ld_cnt;
  logic ld_prev;

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  function automatic logic outbit(int p, int b, int s);
    return ((p * 3 + b * 5 + s) % 7) < 3;
  endfunction

  function automatic logic inbit(int p, int b, int s);
    return ((p * 5 + b * 3 + s * 2) % 5) < 2;
  endfunction

  // external chain model: new input bit on each serial clock rise
  initial begin
    sdi_i = 1'b0;
    forever begin
      @(posedge sclk_o);
      if (nrise < 64) obs[nrise] = sdo_o;
      sdi_i = (nrise < nexp) ? inbit(op[nrise], ob[nrise], cur_seed) : 1'b0;
      nrise++;
    end
  end

  // pulse width / spacing monitor, sampled away from the active edge
  initial begin
    hi_run = 0; last_hi = 0; ld_run = 0; last_ld = 0;
    ld_t0 = 0; ld_t1 = 0; ld_cnt = 0; ld_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (sclk_o) hi_run++;
      else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
      if (sload_o) ld_run++;
      else if (ld_run > 0) begin last_ld = ld_run; ld_run = 0; end
      if (sload_o && !ld_prev) begin ld_t0 = ld_t1; ld_t1 = cyc; ld_cnt++; end
      ld_prev = sload_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = 6'(a);
    #1;
    d = rd_data;
  endtask

  task automatic do_burst(input logic [7:0] m, input int wid, input int dv, input int seed);
    logic [31:0] v, word, expv;
    int per, mism;
    per = (dv < 2) ? 2 : dv;
    cur_seed = seed;
    nexp = 0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (m[p]) begin
        for (int b = 0; b <= wid; b++) begin
          op[nexp] = p; ob[nexp] = b; nexp++;
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      word = '0;
      for (int b = 0; b < MB; b++) begin
        logic o;
        o = outbit(p, b, seed);
        word[3*b +: 3] = {~o, ~o, o};
      end
      wr(32 + p, word);
    end
    wr(1, 32'(dv));
    wr(2, {24'd0, m});
    nrise = 0;
    wr(0, 32'h8 | 32'(wid));
    for (int i = 0; i < 4000; i++) begin
      rd(0, v);
      if (!v[3]) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(v[3] == 1'b0, "R7 shot clear", longint'(v[3]), 0);
    chk(nrise == nexp, "R1 bit count", nrise, nexp);
    mism = 0;
    for (int k = 0; k < nexp && k < 64; k++)
      if (obs[k] !== outbit(op[k], ob[k], seed)) mism++;
    chk(mism == 0, "R2,R3 sdo sequence", mism, 0);
    chk(last_ld == per, "R6 load width", last_ld, per);
    if (nexp > 0) chk(last_hi == per - per / 2, "R5 sclk high", last_hi, per - per / 2);
    for (int n = 0; n < MB; n++) begin
      expv = '0;
      for (int p = 0; p < NP; p++)
        if (m[p] && n <= wid) expv[p] = inbit(p, n, seed);
      rd(4 + n, v);
      chk(v == expv, "R4 input reg", v, expv);
    end
  endtask

  initial begin
    logic [31:0] v;
    int c0;
    nchk = 0; nfail = 0; nrise = 0; nexp = 0; cur_seed = 0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(!sclk_o && !sdo_o && !sload_o, "R10 outputs", {sclk_o, sdo_o, sload_o}, 0);
    rd(0, v); chk(v == 0, "R10 ctrl", v, 0);
    rd(1, v); chk(v == 0, "R10 div", v, 0);
    rd(4, v); chk(v == 0, "R10 input", v, 0);
    repeat (10) @(negedge clk);
    chk(ld_cnt == 0, "R10 idle", ld_cnt, 0);

    for (int i = 0; i < 6; i++)
      do_burst(VEC[i][31:24], int'(VEC[i][23:22]), int'(VEC[i][21:10]), int'(VEC[i][9:0]));

    // R11 empty mask: load only, inputs cleared
    do_burst(8'h00, 3, 3, 7);

    // R9 repeat spacing: 2 bits, P=2, g=1 -> 2*(2+1+2)+1
    wr(1, 32'd2);
    wr(2, 32'h03);
    wr(0, 32'h14);
    repeat (80) @(negedge clk);
    chk(ld_t1 - ld_t0 == 11, "R9 spacing", ld_t1 - ld_t0, 11);

    // R8 shot bit stays set while repeating
    wr(0, 32'h1C);
    repeat (60) @(negedge clk);
    rd(0, v);
    chk(v[3] == 1'b1, "R8 shot held", longint'(v[3]), 1);

    // R9 stop after clearing repeat mode
    wr(0, 32'h0);
    repeat (40) @(negedge clk);
    c0 = ld_cnt;
    repeat (60) @(negedge clk);
    chk(ld_cnt == c0, "R9 stop", ld_cnt, c0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule